// File: doc/BRIEF.md
# Bus Cycle Stepping Responder

This block stands on the bus of a simple 8-bit processor and serves as its memory and as the controller of its bus cycles. It spots each new transfer request and captures the address, the direction and a 2-bit cycle kind. It raises the processor's wait (cycle-extension) input at once, so every cycle lasts exactly as long as the block decides. During the hold a write is stored and a read is fetched from a small internal byte RAM.

Two modes decide when a held cycle is let go. In run mode the block releases wait by itself after a programmable delay. In step mode a monitor step pulse releases exactly one machine cycle. Every completed cycle is logged as a record into a trace FIFO, which the monitor drains. The FIFO has a sticky overflow flag.

The RAM is 4 KiB and mirrors across the whole 16-bit address space. A synchronous reset empties the trace FIFO and clears the overflow flag. It leaves the RAM contents untouched.

Top module: `bus_step_responder`

## Requirements
- R1: `bus_wait` is high in the same clock cycle as an idle block sees `bus_req` high (combinational path). It stays high until the block releases that cycle.
- R2: After a release, `bus_wait` stays low while `bus_req` remains high. The block re-arms only after `bus_req` has been low at a rising edge, and the next request is held again.
- R3: In run mode (`step_mode`=0), `bus_wait` stays high for exactly `run_delay`+1 rising edges after the edge that captures the request (`run_delay` 0..15).
- R4: In step mode a cycle is held for as long as no step pulse arrives. One `step_cmd` pulse during a hold releases that single cycle and adds exactly one trace record.
- R5: A `step_cmd` pulse given while no cycle is held has no effect: the next cycle is still held.
- R6: `bus_rdata_oe` is high only in read cycles (`bus_wr`=0), from the capturing edge until the edge after `bus_req` drops. At release, `bus_rdata` carries the stored byte.
- R7: A write cycle (`bus_wr`=1) stores `bus_wdata` at RAM index `bus_addr[11:0]`. Address bits 15:12 are ignored, so the 4 KiB mirrors across the 64 KiB space.
- R8: Each released cycle pushes one record, in cycle order, with this layout: `trace_rec[26:11]`=address, `[10:3]`=data (the written byte, or the byte returned on a read), `[2]`=1 for write, `[1:0]`=cycle kind. `trace_valid` shows that the head record is present, and `trace_pop` removes it.
- R9: In step mode, while `trace_full` is high (16 records held), a step pulse is ignored and the cycle stays held.
- R10: In run mode a cycle that completes while the FIFO is full is still released. Its record is dropped, `trace_ovf` is set and stays set, and the stored records are kept.
- R11: A synchronous reset (`rst`=1 at a rising edge) empties the trace FIFO and clears `trace_ovf`, but keeps the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Processor transfer request, active high |
| bus_wr | input | 1 | Direction: 1 write, 0 read |
| bus_kind | input | 2 | Cycle kind code, logged only |
| bus_addr | input | 16 | Transfer address |
| bus_wdata | input | 8 | Write data from processor |
| bus_rdata | output | 8 | Read data to processor |
| bus_rdata_oe | output | 1 | Read data driver enable |
| bus_wait | output | 1 | Cycle-extension request to processor, active high |
| step_mode | input | 1 | 1 step mode, 0 run mode |
| step_cmd | input | 1 | Monitor step pulse |
| run_delay | input | 4 | Run-mode release delay in clocks |
| trace_pop | input | 1 | Remove head trace record |
| trace_rec | output | 27 | Head trace record |
| trace_valid | output | 1 | FIFO not empty |
| trace_full | output | 1 | FIFO holds 16 records |
| trace_ovf | output | 1 | Sticky overflow flag |

## Verification
The hold length is measured in run mode at delays 0, 5 and 15, which separates an off-by-one in the delay counter from a counter that ignores its load value. Writes and reads go to distinct addresses, including a read through a mirror alias of an earlier write, which exposes wrong index slicing and a wrong read source. In step mode the cycle is held through many idle clocks with a stray step pulse given first, so a step latched early or a release without a step is caught. The FIFO is then filled and driven once in step mode and once in run mode, which tells the step gate apart from the drop-and-flag path. A reset with data in RAM shows which state is cleared.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int KIND_W = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              wr;
    logic [KIND_W-1:0] kind;
  } trace_rec_t;

  localparam int REC_W = $bits(trace_rec_t);

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_DONE} cyc_state_e;

  // byte returned or stored for a cycle, as logged
  function automatic logic [DATA_W-1:0] logged_byte(input logic wr,
      input logic [DATA_W-1:0] wbyte, input logic [DATA_W-1:0] rbyte);
    return wr ? wbyte : rbyte;
  endfunction

  // countdown step of the run-mode delay
  function automatic logic [3:0] dec_sat(input logic [3:0] v);
    return (v == 4'd0) ? 4'd0 : v - 4'd1;
  endfunction
endpackage

// File: rtl/bsr_byte_ram.sv
`timescale 1ns/1ps
module bsr_byte_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store[idx] <= wdata;
      rdata <= store[idx];
    end
  end
endmodule

// File: rtl/bsr_trace_fifo.sv
`timescale 1ns/1ps
module bsr_trace_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 27
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full,
  output logic         ovf
);
  localparam int PW = $clog2(DEPTH);
  logic [W-1:0] slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   count;
  logic          take, give;

  assign valid = (count != '0);
  assign full  = (count == (PW+1)'(DEPTH));
  assign give  = pop && valid;
  assign take  = push && (!full || give);
  assign dout  = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (take) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (take) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (give) rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + (PW+1)'(take) - (PW+1)'(give);
      if (push && !take) ovf <= 1'b1;
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> ($stable(count) && ovf));
  p_depth_bound_r8: assert property (@(posedge clk) disable iff (rst)
    count <= (PW+1)'(DEPTH));
endmodule

// File: rtl/bsr_cycle_fsm.sv
`timescale 1ns/1ps
module bsr_cycle_fsm
  import bsr_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_req,
  input  logic             step_mode,
  input  logic             step_cmd,
  input  logic [DLY_W-1:0] run_delay,
  input  logic             fifo_full,
  output logic             start_now,
  output logic             release_now,
  output logic             in_hold,
  output logic             in_done
);
  cyc_state_e       state;
  logic [DLY_W-1:0] cnt;
  logic             go;

  assign in_hold     = (state == ST_HOLD);
  assign in_done     = (state == ST_DONE);
  assign start_now   = (state == ST_IDLE) && bus_req;
  assign go          = step_mode ? (step_cmd && !fifo_full) : (cnt == '0);
  assign release_now = in_hold && go;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (bus_req) begin
          state <= ST_HOLD;
          cnt   <= run_delay;
        end
        ST_HOLD: begin
          if (go) state <= ST_DONE;
          else if (!step_mode) cnt <= dec_sat(cnt);
        end
        ST_DONE: if (!bus_req) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_step_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (in_hold && step_mode && fifo_full) |=> in_hold);
  p_hold_no_step_r4: assert property (@(posedge clk) disable iff (rst)
    (in_hold && step_mode && !step_cmd) |=> in_hold);
  p_done_until_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (in_done && bus_req) |=> in_done);
endmodule

// File: rtl/bus_step_responder.sv
`timescale 1ns/1ps
module bus_step_responder
  import bsr_pkg::*;
#(
  parameter int MEM_AW      = 12,
  parameter int TRACE_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_req,
  input  logic        bus_wr,
  input  logic [1:0]  bus_kind,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        bus_rdata_oe,
  output logic        bus_wait,
  input  logic        step_mode,
  input  logic        step_cmd,
  input  logic [3:0]  run_delay,
  input  logic        trace_pop,
  output logic [26:0] trace_rec,
  output logic        trace_valid,
  output logic        trace_full,
  output logic        trace_ovf
);
  logic start_now, release_now, in_hold, in_done;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_wdata, ram_q;
  logic              cap_wr;
  logic [KIND_W-1:0] cap_kind;
  trace_rec_t        new_rec;

  bsr_cycle_fsm #(.DLY_W(4)) fsm_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .step_mode(step_mode),
    .step_cmd(step_cmd), .run_delay(run_delay), .fifo_full(trace_full),
    .start_now(start_now), .release_now(release_now),
    .in_hold(in_hold), .in_done(in_done));

  bsr_byte_ram #(.AW(MEM_AW), .DW(DATA_W)) ram_i (
    .clk(clk), .en(start_now), .we(start_now && bus_wr),
    .idx(bus_addr[MEM_AW-1:0]), .wdata(bus_wdata), .rdata(ram_q));

  assign bus_wait  = bus_req && !in_done;
  assign bus_rdata = ram_q;

  always_ff @(posedge clk) begin
    if (start_now) begin
      cap_addr  <= bus_addr;
      cap_wr    <= bus_wr;
      cap_kind  <= bus_kind;
      cap_wdata <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata_oe <= 1'b0;
    else if (start_now) bus_rdata_oe <= !bus_wr;
    else if (in_done && !bus_req) bus_rdata_oe <= 1'b0;
  end

  always_comb begin
    new_rec.addr = cap_addr;
    new_rec.data = logged_byte(cap_wr, cap_wdata, ram_q);
    new_rec.wr   = cap_wr;
    new_rec.kind = cap_kind;
  end

  bsr_trace_fifo #(.DEPTH(TRACE_DEPTH), .W(REC_W)) fifo_i (
    .clk(clk), .rst(rst), .push(release_now), .din(new_rec),
    .pop(trace_pop), .dout(trace_rec), .valid(trace_valid),
    .full(trace_full), .ovf(trace_ovf));

  p_wait_on_new_req_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> bus_wait);
  p_push_then_release_r2: assert property (@(posedge clk) disable iff (rst)
    release_now |=> !bus_wait);
  p_oe_read_only_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata_oe && (in_hold || in_done)) |-> !cap_wr);
  p_oe_off_after_req_r6: assert property (@(posedge clk) disable iff (rst)
    (in_done && $fell(bus_req)) |=> !bus_rdata_oe);
endmodule

// File: tb/bus_step_responder_tb_top.sv
`timescale 1ns/1ps
module bus_step_responder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_req = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_kind = '0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic bus_rdata_oe, bus_wait;
  logic step_mode = 1'b0, step_cmd = 1'b0, trace_pop = 1'b0;
  logic [3:0] run_delay = '0;
  logic [26:0] trace_rec;
  logic trace_valid, trace_full, trace_ovf;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_step_responder dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_kind(bus_kind), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .bus_wait(bus_wait),
    .step_mode(step_mode), .step_cmd(step_cmd), .run_delay(run_delay),
    .trace_pop(trace_pop), .trace_rec(trace_rec), .trace_valid(trace_valid),
    .trace_full(trace_full), .trace_ovf(trace_ovf));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_cycle(input logic [15:0] a, input logic w,
                             input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_kind = k; bus_wdata = d; bus_req = 1'b1;
    #1;
    chk(bus_wait === 1'b1, "R1 wait on request", 32'(bus_wait), 1);
  endtask

  // counts held negedges, samples read data at release, then ends the cycle
  task automatic finish_cycle(input bit advance, output int held,
                              output logic [7:0] rd);
    held = 0;
    if (advance) @(negedge clk);
    while (bus_wait === 1'b1 && held < 100) begin
      chk(bus_rdata_oe === !bus_wr, "R6 oe during hold", 32'(bus_rdata_oe),
          32'(!bus_wr));
      held++;
      @(negedge clk);
    end
    rd = bus_rdata;
    chk(bus_rdata_oe === !bus_wr, "R6 oe at release", 32'(bus_rdata_oe),
        32'(!bus_wr));
    @(negedge clk);
    chk(bus_wait === 1'b0, "R2 wait stays low while req high", 32'(bus_wait), 0);
    bus_req = 1'b0;
    @(negedge clk);
    chk(bus_rdata_oe === 1'b0, "R6 oe off after req drop", 32'(bus_rdata_oe), 0);
  endtask

  task automatic run_cycle(input logic [15:0] a, input logic w,
                           input logic [1:0] k, input logic [7:0] d,
                           output int held, output logic [7:0] rd);
    start_cycle(a, w, k, d);
    finish_cycle(1'b1, held, rd);
  endtask

  task automatic pop_check(input logic [15:0] a, input logic [7:0] d,
                           input logic w, input logic [1:0] k, input string req);
    logic [26:0] exp;
    exp = {a, d, w, k};
    @(negedge clk);
    chk(trace_valid === 1'b1, req, 32'(trace_valid), 1);
    chk(trace_rec === exp, req, 32'(trace_rec), 32'(exp));
    trace_pop = 1'b1;
    @(negedge clk);
    trace_pop = 1'b0;
  endtask

  task automatic step_pulse();
    @(negedge clk); step_cmd = 1'b1;
    @(negedge clk); step_cmd = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_wait === 1'b0 && bus_rdata_oe === 1'b0, "R11 reset outputs",
        32'({bus_wait, bus_rdata_oe}), 0);
    chk(trace_valid === 1'b0 && trace_full === 1'b0 && trace_ovf === 1'b0,
        "R11 reset trace", 32'({trace_valid, trace_full, trace_ovf}), 0);
  endtask

  task automatic t_run_delays();
    int h; logic [7:0] rd;
    step_mode = 1'b0;
    run_delay = 4'd0;
    run_cycle(16'h0123, 1'b1, 2'd1, 8'hA5, h, rd);
    chk(h == 1, "R3 delay 0", 32'(h), 1);
    run_delay = 4'd5;
    run_cycle(16'h0456, 1'b1, 2'd2, 8'h3C, h, rd);
    chk(h == 6, "R3 delay 5", 32'(h), 6);
    run_delay = 4'd15;
    run_cycle(16'h5123, 1'b0, 2'd0, 8'h00, h, rd);
    chk(h == 16, "R3 delay 15", 32'(h), 16);
    chk(rd == 8'hA5, "R7 mirrored read", 32'(rd), 32'hA5);
    run_delay = 4'd2;
    run_cycle(16'hF456, 1'b0, 2'd3, 8'h00, h, rd);
    chk(rd == 8'h3C, "R6 read data", 32'(rd), 32'h3C);
    pop_check(16'h0123, 8'hA5, 1'b1, 2'd1, "R8 record 0");
    pop_check(16'h0456, 8'h3C, 1'b1, 2'd2, "R8 record 1");
    pop_check(16'h5123, 8'hA5, 1'b0, 2'd0, "R8 record 2");
    pop_check(16'hF456, 8'h3C, 1'b0, 2'd3, "R8 record 3");
    @(negedge clk);
    chk(trace_valid === 1'b0, "R8 drained", 32'(trace_valid), 0);
  endtask

  task automatic t_step();
    int h; logic [7:0] rd;
    step_mode = 1'b1;
    step_pulse();  // stray pulse while idle
    start_cycle(16'h0777, 1'b1, 2'd1, 8'h5A);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(bus_wait === 1'b1, "R5 R4 held without step", 32'(bus_wait), 1);
      chk(trace_valid === 1'b0, "R4 no record while held", 32'(trace_valid), 0);
    end
    step_pulse();
    finish_cycle(1'b0, h, rd);
    pop_check(16'h0777, 8'h5A, 1'b1, 2'd1, "R4 one record per step");
    @(negedge clk);
    chk(trace_valid === 1'b0, "R4 only one record", 32'(trace_valid), 0);
    start_cycle(16'h1777, 1'b0, 2'd0, 8'h00);
    repeat (3) @(negedge clk);
    step_pulse();
    finish_cycle(1'b0, h, rd);
    chk(rd == 8'h5A, "R4 stepped read", 32'(rd), 32'h5A);
    pop_check(16'h1777, 8'h5A, 1'b0, 2'd0, "R4 second step record");
  endtask

  task automatic t_full();
    int h; logic [7:0] rd;
    step_mode = 1'b0;
    run_delay = 4'd0;
    for (int i = 0; i < 16; i++)
      run_cycle(16'h0200 + 16'(i), 1'b1, 2'd1, 8'(i + 16), h, rd);
    @(negedge clk);
    chk(trace_full === 1'b1 && trace_ovf === 1'b0, "R10 full no ovf",
        32'({trace_full, trace_ovf}), 2);
    step_mode = 1'b1;
    start_cycle(16'h0300, 1'b1, 2'd2, 8'h77);
    step_pulse();
    repeat (3) begin
      @(negedge clk);
      chk(bus_wait === 1'b1, "R9 step ignored when full", 32'(bus_wait), 1);
    end
    pop_check(16'h0200, 8'd16, 1'b1, 2'd1, "R9 head while full");
    step_pulse();
    finish_cycle(1'b0, h, rd);
    chk(trace_full === 1'b1, "R9 full again", 32'(trace_full), 1);
    step_mode = 1'b0;
    run_cycle(16'h0301, 1'b1, 2'd3, 8'h99, h, rd);
    chk(h == 1, "R10 released when full", 32'(h), 1);
    chk(trace_ovf === 1'b1, "R10 ovf set", 32'(trace_ovf), 1);
    pop_check(16'h0201, 8'd17, 1'b1, 2'd1, "R10 contents kept");
    repeat (2) @(negedge clk);
    chk(trace_ovf === 1'b1, "R10 ovf sticky", 32'(trace_ovf), 1);
  endtask

  task automatic t_reset_keeps_ram();
    int h; logic [7:0] rd;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(trace_valid === 1'b0 && trace_ovf === 1'b0, "R11 trace cleared",
        32'({trace_valid, trace_ovf}), 0);
    run_cycle(16'h0123, 1'b0, 2'd0, 8'h00, h, rd);
    chk(rd == 8'hA5, "R11 RAM kept", 32'(rd), 32'hA5);
    run_cycle(16'h0300, 1'b0, 2'd0, 8'h00, h, rd);
    chk(rd == 8'h77, "R7 stepped write stored", 32'(rd), 32'h77);
  endtask

  initial begin
    t_reset();
    t_run_delays();
    t_step();
    t_full();
    t_reset_keeps_ram();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule